// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Layer

This block holds one layer of spiking neurons and advances it by one discrete time step each time `start` is pulsed. The binary spike vector from the preceding layer is captured at that pulse. The layer then walks through its neurons one at a time. For each neuron it first scales the stored membrane potential by a fixed leak factor. It then visits every input and adds that input's signed weight only where the input spike is 1. Weights of silent inputs are skipped, so no multiplier sits in the synaptic path. Last, it compares the result with a firing threshold and writes back the new potential and refractory count.

A neuron that fires has its potential cleared to zero. Its refractory counter is loaded so that it stays silent for a fixed number of later steps, even if its potential climbs past the threshold during that window. The full output spike vector is presented together with a one-cycle `done` pulse. Weights live in a local memory that is written through a simple word port.

Top module: `lif_layer`

## Requirements
- R1: After reset, `spike_out` is all zero, `done` is low, every membrane potential is zero and every refractory counter is zero.
- R2: In each step a neuron's new potential is floor(BETA × V / 256) + (the sum of its weights over inputs whose spike bit is 1). BETA is an unsigned Q0.8 constant, and the leak is applied before any weight is added.
- R3: The potential saturates at the signed limits of V_W bits (−2^(V_W−1) and 2^(V_W−1)−1) after every weight addition and never wraps.
- R4: A neuron whose refractory counter is zero fires when its new potential is strictly greater than THRESH. A firing neuron's stored potential becomes 0.
- R5: On firing, the neuron's refractory counter is set to REFRAC. During each of the next REFRAC steps the counter is decremented and the neuron does not fire, whatever its potential. During those steps the potential is still stored as computed.
- R6: An input whose spike bit is 0 adds nothing. A step with no input spikes only applies the leak.
- R7: `done` pulses for exactly one cycle, N×(N_IN+2) clock edges after the edge that accepts `start`. `spike_out` changes only on that edge, with bit n set when neuron n fired, and holds otherwise.
- R8: `spike_in` is sampled only on the edge that accepts `start`. A `start` pulse that arrives while a step is in progress is ignored.
- R9: The weight from input i to neuron n is stored at address n×N_IN + i and is written when `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Advance the layer by one time step |
| spike_in | input | N_IN | Spikes from the preceding layer |
| wr_en | input | 1 | Weight memory write enable |
| wr_addr | input | AW | Weight address, n×N_IN + i |
| wr_data | input | W_W | Signed weight |
| spike_out | output | N | Spikes produced in the last step |
| done | output | 1 | One-cycle pulse at the end of a step |

## Verification
The leak, the saturating accumulation, the threshold test and the refractory gate all act on the same neuron in the same step. The sharpest overlap is a neuron that crosses the threshold in a step where its refractory counter is still running. The bench provokes this by driving all inputs on heavily weighted neurons for many consecutive steps, so potentials exceed the threshold during the silent window. A second overlap comes from strongly negative weights that drive a potential into the lower saturation limit. The weights are then turned positive, so leak, clamping and firing interact on recovery. A behavioural model that updates integer potentials and counters at each accepted start predicts `spike_out` and `done` on every clock, and any mismatch is judged against it.

// File: rtl/lif_layer.sv
module lif_layer #(
  parameter int N = 20,
  parameter int N_IN = 16,
  parameter int W_W = 8,
  parameter int V_W = 16,
  parameter logic [7:0] BETA = 8'd230,
  parameter int THRESH = 1000,
  parameter int REFRAC = 3,
  localparam int AW = $clog2(N * N_IN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_IN-1:0]   spike_in,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [W_W-1:0]    wr_data,
  output logic [N-1:0]      spike_out,
  output logic              done
);
  localparam int NW = $clog2(N);
  localparam int IW = $clog2(N_IN);
  localparam int RW = $clog2(REFRAC + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_LEAK = 2'd1, S_ACC = 2'd2, S_FIRE = 2'd3;
  localparam logic signed [V_W-1:0] TH = V_W'(THRESH);
  localparam logic signed [V_W-1:0] VMAX = {1'b0, {(V_W-1){1'b1}}};
  localparam logic signed [V_W-1:0] VMIN = {1'b1, {(V_W-1){1'b0}}};
  localparam logic [RW-1:0] RLOAD = RW'(REFRAC);

  logic [1:0]               st;
  logic [NW-1:0]            n_q;
  logic [IW-1:0]            i_q;
  logic [N_IN-1:0]          spk_q;
  logic [N-1:0]             nxt_q, nxt_w;
  logic signed [W_W-1:0]    wmem [N*N_IN];
  logic signed [V_W-1:0]    vmem [N];
  logic [RW-1:0]            rmem [N];
  logic signed [V_W-1:0]    acc, leak_v, add_v;
  logic signed [V_W+7:0]    prod;
  logic signed [V_W:0]      sum;
  logic signed [W_W-1:0]    wcur;
  logic [AW-1:0]            raddr;
  logic                     fire_now, last_n, last_i;

  assign raddr  = AW'(n_q) * AW'(N_IN) + AW'(i_q);
  assign wcur   = wmem[raddr];
  assign prod   = vmem[n_q] * $signed({1'b0, BETA});
  assign leak_v = V_W'(prod >>> 8);
  assign sum    = {acc[V_W-1], acc} + (V_W+1)'(wcur);
  assign add_v  = (sum[V_W] != sum[V_W-1]) ? (sum[V_W] ? VMIN : VMAX) : sum[V_W-1:0];
  assign fire_now = (st == S_FIRE) && (acc > TH) && (rmem[n_q] == '0);
  assign last_n = (n_q == NW'(N - 1));
  assign last_i = (i_q == IW'(N_IN - 1));

  always_comb begin
    nxt_w = nxt_q;
    nxt_w[n_q] = fire_now;
  end

  always_ff @(posedge clk)
    if (wr_en) wmem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      n_q <= '0;
      i_q <= '0;
      spk_q <= '0;
      nxt_q <= '0;
      acc <= '0;
      spike_out <= '0;
      done <= 1'b0;
      for (int k = 0; k < N; k++) begin
        vmem[k] <= '0;
        rmem[k] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          spk_q <= spike_in;
          n_q <= '0;
          st <= S_LEAK;
        end
        S_LEAK: begin
          acc <= leak_v;
          i_q <= '0;
          st <= S_ACC;
        end
        S_ACC: begin
          if (spk_q[i_q]) acc <= add_v;
          i_q <= i_q + 1'b1;
          if (last_i) st <= S_FIRE;
        end
        default: begin
          vmem[n_q] <= fire_now ? '0 : acc;
          if (fire_now) rmem[n_q] <= RLOAD;
          else if (rmem[n_q] != '0) rmem[n_q] <= rmem[n_q] - 1'b1;
          nxt_q <= nxt_w;
          if (last_n) begin
            spike_out <= nxt_w;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            n_q <= n_q + 1'b1;
            st <= S_LEAK;
          end
        end
      endcase
    end
  end
endmodule

module lif_layer_chk #(
  parameter int N = 20,
  parameter int N_IN = 16,
  parameter int W_W = 8,
  parameter int V_W = 16,
  parameter int REFRAC = 3,
  localparam int NW = $clog2(N),
  localparam int IW = $clog2(N_IN),
  localparam int RW = $clog2(REFRAC + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic                  done,
  input logic [N-1:0]          spike_out,
  input logic [1:0]            st,
  input logic [NW-1:0]         n_q,
  input logic [IW-1:0]         i_q,
  input logic [N_IN-1:0]       spk_q,
  input logic signed [V_W-1:0] acc,
  input logic signed [W_W-1:0] wcur,
  input logic                  fire_now,
  input logic signed [V_W-1:0] vmem [N],
  input logic [RW-1:0]         rmem [N]
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> spike_out == $past(spike_out));
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd2 && spk_q[i_q] && !wcur[W_W-1]) |=> acc >= $past(acc));
  assert_fire_clears_R4: assert property (@(posedge clk) disable iff (rst)
    fire_now |=> vmem[$past(n_q)] == '0);
  assert_refr_load_R5: assert property (@(posedge clk) disable iff (rst)
    fire_now |=> rmem[$past(n_q)] == RW'(REFRAC));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (st != 2'd0 && start) |=> $stable(spk_q));
endmodule

bind lif_layer lif_layer_chk #(.N(N), .N_IN(N_IN), .W_W(W_W), .V_W(V_W), .REFRAC(REFRAC)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .spike_out(spike_out),
  .st(st), .n_q(n_q), .i_q(i_q), .spk_q(spk_q), .acc(acc), .wcur(wcur),
  .fire_now(fire_now), .vmem(vmem), .rmem(rmem));

// File: tb/lif_layer_test.sv
`timescale 1ns/1ps
module lif_layer_test;
  localparam int N = 6, NI = 8, WW = 8, VW = 12, BETA = 200, TH = 300, RF = 2;
  localparam int AW = $clog2(N * NI);
  localparam int L = N * (NI + 2);
  localparam int VMAXI = 2047, VMINI = -2048;

  logic clk = 0, rst = 1, start = 0, wr_en = 0;
  logic [NI-1:0] spike_in = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [N-1:0] spike_out;
  logic done;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lif_layer #(.N(N), .N_IN(NI), .W_W(WW), .V_W(VW), .BETA(8'(BETA)),
              .THRESH(TH), .REFRAC(RF)) uut (
    .clk(clk), .rst(rst), .start(start), .spike_in(spike_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .spike_out(spike_out), .done(done));

  int mv [N];
  int mr [N];
  int mw [N*NI];
  int rem;
  logic [N-1:0] pend, exp_spk;
  logic exp_done;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin mv[k] = 0; mr[k] = 0; end
      rem = 0; exp_done = 0; exp_spk = '0; pend = '0;
    end else begin
      if (wr_en) mw[wr_addr] = int'($signed(wr_data));
      exp_done = 0;
      if (rem > 0) begin
        rem--;
        if (rem == 0) begin exp_done = 1; exp_spk = pend; end
      end else if (start) begin
        for (int n = 0; n < N; n++) begin
          int v;
          v = (mv[n] * BETA) >>> 8;
          for (int i = 0; i < NI; i++)
            if (spike_in[i]) begin
              v += mw[n*NI + i];
              if (v > VMAXI) v = VMAXI;
              if (v < VMINI) v = VMINI;
            end
          if (v > TH && mr[n] == 0) begin
            pend[n] = 1; mv[n] = 0; mr[n] = RF;
          end else begin
            pend[n] = 0; mv[n] = v;
            if (mr[n] > 0) mr[n]--;
          end
        end
        rem = L;
      end
    end
  end

  task automatic expect_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (!rst && !finished) begin
      expect_eq("R7 done per cycle", int'(done), int'(exp_done));
      expect_eq("R7 spike_out per cycle", int'(spike_out), int'(exp_spk));
    end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = WW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_step(logic [NI-1:0] p, string tag);
    @(negedge clk);
    start = 1; spike_in = p;
    @(negedge clk);
    start = 0; spike_in = ~p;
    repeat (L) @(negedge clk);
    expect_eq({tag, " done at end of step"}, int'(done), 1);
    expect_eq({tag, " spikes"}, int'(spike_out), int'(exp_spk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    expect_eq("R1 reset spike_out", int'(spike_out), 0);
    expect_eq("R1 reset done", int'(done), 0);
    // R9: weight for neuron n, input i at n*NI+i
    for (int n = 0; n < N; n++)
      for (int i = 0; i < NI; i++)
        wr(n*NI + i, (n == 5) ? -128 : ((n*37 + i*23) % 90) - 20);
    do_step('0, "R1 zero potentials");
    for (int s = 0; s < 4; s++) do_step(8'b0000_1000, "R9 single input");
    for (int s = 0; s < 7; s++) do_step(8'hFF, "R5 refractory under drive");
    for (int s = 0; s < 3; s++) do_step('0, "R6 no input leak only");
    for (int s = 0; s < 4; s++) do_step(8'b1010_0101, "R2 leak plus sparse sum");
    for (int s = 0; s < 3; s++) do_step(8'b0101_1010, "R4 threshold");
    for (int i = 0; i < NI; i++) wr(5*NI + i, 127);
    for (int s = 0; s < 5; s++) do_step(8'hFF, "R3 recovery from saturation");
    // R8: start while busy ignored, spike_in sampled once
    @(negedge clk);
    start = 1; spike_in = 8'b0011_0011;
    @(negedge clk);
    start = 1; spike_in = 8'hFF;
    @(negedge clk);
    start = 0; spike_in = 8'hC3;
    repeat (L - 1) @(negedge clk);
    expect_eq("R8 done", int'(done), 1);
    expect_eq("R8 spikes", int'(spike_out), int'(exp_spk));
    @(negedge clk);
    expect_eq("R7 single-cycle done", int'(done), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule